// File: doc/BRIEF.md
# Real-Time Clock Command Front End

This block sits between a host register bus and an internal calendar clock. The host sees three 32-bit registers: a control register and two time value registers. It sets or reads the time with a polled handshake. The host first waits until the ready bit is high and then clears the control register. For a set, it loads the low value register and then the high one, and writes the set command. For a read, it writes the read command and fetches the two value registers once ready returns. A separate failure bit reports whether the last command was refused.

The clock keeps seven BCD-style fields: year counted from 2000, month, day, weekday, hour, minute and second. The weekday is a plain binary count from 0 to 6. A one-cycle `tick` pulse advances the seconds. The carry then ripples through the minutes, hours, day (the weekday moves with it), month and year, using calendar month lengths. Every command holds the interface busy for a fixed number of cycles. A set command checks the supplied fields before it loads them.

The register bus is a plain single-cycle write strobe with a combinational read mux. It has no valid/ready stream and no back-pressure. A write that arrives while the block is busy is dropped, and the host is expected to poll first.

Top module: `rtc_cmd_front`

## Requirements
- R1: After reset the control register reads 0x0000_8000, both value registers read zero, and the clock holds 2000-01-01, weekday 0, 00:00:00.
- R2: Address 0 is control, with bit 15 = ready, bit 14 = fail and all other bits zero. Address 1 is the low value register, address 2 is the high value register, and address 3 reads zero.
- R3: Writing 0 to control while ready clears fail and leaves ready at 1.
- R4: Writing 1 (set) or 2 (read) to control while ready drops ready on the next cycle and keeps it low for exactly BUSY_CYCLES (default 8) cycles.
- R5: A set with valid fields loads the clock from the value registers when it completes and leaves fail at 0.
- R6: A set fails, setting fail to 1 and leaving the clock unchanged, in any of these cases: any BCD nibble is above 9, month is outside 01..12, day is outside 01..31, hour is above 23, minute or second is above 59, or weekday is above 6.
- R7: A read command copies the clock into the value registers when it completes and clears fail. Low register bytes 0..3 hold year, month, day and weekday. High register bytes 0..2 hold hour, minute and second, and byte 3 reads zero.
- R8: A control write of any value other than 0, 1 or 2 while ready sets fail on the next cycle and ready stays 1.
- R9: While ready is 0, writes to any register are ignored.
- R10: Each tick advances the seconds. 59 seconds wraps to 00 and carries into the minutes, which carry into the hours in the same way, and 23 hours wraps to 00 and carries into the day. The weekday steps with each day carry and wraps from 6 to 0.
- R11: The day wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. February ends at 29 when the year value is divisible by 4 and at 28 otherwise. Month 12 wraps to 01, and year 99 wraps to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse that advances the clock by one second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |

## Verification
A stuck or miscounted busy counter shows up on control bit 15 within BUSY_CYCLES+1 cycles of a command. A failure flag that does not update shows up on bit 14 in the cycle after the command completes. A fault in the carry chain or the month-length table changes no port directly. It appears only when a read command copies the clock out, BUSY_CYCLES cycles later. For this reason the bench follows every set and every tick sequence with a read command. A validator fault appears in two ways: as a wrong fail bit, and as a clock that was or was not overwritten.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] day;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;

  localparam int READY_BIT = 15;
  localparam int FAIL_BIT  = 14;

  function automatic logic nibbles_ok(input logic [7:0] b);
    return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'd0};
    return b + 8'd1;
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] month,
                                                input logic [7:0] year);
    logic [7:0] ybin;
    ybin = bcd_to_bin(year);
    case (month)
      8'h02:                      return (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_time_check.sv
module rtc_time_check
  import rtc_pkg::*;
(
  input  rtc_time_t cand,
  output logic      ok
);
  logic digits_ok;
  logic ranges_ok;

  always_comb begin
    digits_ok = nibbles_ok(cand.year) && nibbles_ok(cand.month) &&
                nibbles_ok(cand.day)  && nibbles_ok(cand.hour)  &&
                nibbles_ok(cand.min)  && nibbles_ok(cand.sec);
    ranges_ok = (cand.month >= 8'h01) && (cand.month <= 8'h12) &&
                (cand.day   >= 8'h01) && (cand.day   <= 8'h31) &&
                (cand.hour  <= 8'h23) && (cand.min   <= 8'h59) &&
                (cand.sec   <= 8'h59) && (cand.wday  <= 8'd6);
    ok = digits_ok && ranges_ok;
  end
endmodule

// File: rtl/rtc_time_keeper.sv
module rtc_time_keeper
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now
);
  localparam rtc_time_t RESET_TIME = '{year: 8'h00, month: 8'h01, day: 8'h01,
                                       wday: 8'd0, hour: 8'h00, min: 8'h00,
                                       sec: 8'h00};

  rtc_time_t nxt;
  logic c_min, c_hour, c_day, c_month, c_year;

  always_comb begin
    nxt     = now;
    c_min   = 1'b0;
    c_hour  = 1'b0;
    c_day   = 1'b0;
    c_month = 1'b0;
    c_year  = 1'b0;
    if (tick) begin
      if (now.sec >= 8'h59) begin nxt.sec = 8'h00; c_min = 1'b1; end
      else nxt.sec = bcd_inc(now.sec);
      if (c_min) begin
        if (now.min >= 8'h59) begin nxt.min = 8'h00; c_hour = 1'b1; end
        else nxt.min = bcd_inc(now.min);
      end
      if (c_hour) begin
        if (now.hour >= 8'h23) begin nxt.hour = 8'h00; c_day = 1'b1; end
        else nxt.hour = bcd_inc(now.hour);
      end
      if (c_day) begin
        nxt.wday = (now.wday >= 8'd6) ? 8'd0 : now.wday + 8'd1;
        if (now.day >= month_last_day(now.month, now.year)) begin
          nxt.day = 8'h01;
          c_month = 1'b1;
        end else nxt.day = bcd_inc(now.day);
      end
      if (c_month) begin
        if (now.month >= 8'h12) begin nxt.month = 8'h01; c_year = 1'b1; end
        else nxt.month = bcd_inc(now.month);
      end
      if (c_year) nxt.year = (now.year >= 8'h99) ? 8'h00 : bcd_inc(now.year);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    now <= RESET_TIME;
    else if (load) now <= load_val;
    else           now <= nxt;
  end
endmodule

// File: rtl/rtc_cmd_ctrl.sv
module rtc_cmd_ctrl #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_val,
  input  logic        set_ok,
  output logic        ready,
  output logic        fail,
  output logic        do_set,
  output logic        do_get
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             op_is_set;
  logic             done;

  assign ready  = (cnt == '0);
  assign done   = (cnt == CNT_ONE);
  assign do_set = done && op_is_set && set_ok;
  assign do_get = done && !op_is_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      op_is_set <= 1'b0;
      fail      <= 1'b0;
    end else if (ready) begin
      if (cmd_wr) begin
        case (cmd_val)
          32'd0: fail <= 1'b0;
          32'd1: begin cnt <= CNT_LOAD; op_is_set <= 1'b1; end
          32'd2: begin cnt <= CNT_LOAD; op_is_set <= 1'b0; end
          default: fail <= 1'b1;
        endcase
      end
    end else begin
      cnt <= cnt - CNT_ONE;
      if (done) fail <= op_is_set ? !set_ok : 1'b0;
    end
  end
endmodule

// File: rtl/rtc_cmd_front.sv
module rtc_cmd_front
  import rtc_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  logic        ready, fail, do_set, do_get, set_ok;
  logic [31:0] val_lo;
  logic [23:0] val_hi;
  rtc_time_t   cand, cur_time;
  logic [7:0]  cur_sec;

  assign cur_sec = cur_time.sec;

  assign cand = '{year: val_lo[7:0], month: val_lo[15:8], day: val_lo[23:16],
                  wday: val_lo[31:24], hour: val_hi[7:0], min: val_hi[15:8],
                  sec: val_hi[23:16]};

  rtc_cmd_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(reg_wr && reg_addr == ADDR_CTRL), .cmd_val(reg_wdata),
    .set_ok(set_ok), .ready(ready), .fail(fail),
    .do_set(do_set), .do_get(do_get)
  );

  rtc_time_check u_check (.cand(cand), .ok(set_ok));

  rtc_time_keeper u_keep (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(do_set), .load_val(cand), .now(cur_time)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_lo <= '0;
      val_hi <= '0;
    end else if (do_get) begin
      val_lo <= {cur_time.wday, cur_time.day, cur_time.month, cur_time.year};
      val_hi <= {cur_time.sec, cur_time.min, cur_time.hour};
    end else if (ready && reg_wr) begin
      if (reg_addr == ADDR_LO) val_lo <= reg_wdata;
      if (reg_addr == ADDR_HI) val_hi <= reg_wdata[23:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[READY_BIT] = ready;
        reg_rdata[FAIL_BIT]  = fail;
      end
      ADDR_LO: reg_rdata = val_lo;
      ADDR_HI: reg_rdata = {8'd0, val_hi};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_cmd_front_chk.sv
module rtc_cmd_front_chk #(
  parameter int BUSY_CYCLES = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        ready,
  input logic        fail,
  input logic [31:0] val_lo,
  input logic [7:0]  sec
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 2);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] bcnt;
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bcnt <= '0;
    else if (ready) bcnt <= '0;
    else if (bcnt < LIM) bcnt <= bcnt + 1'b1;
  end

  assert_busy_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> bcnt < LIM);
  assert_busy_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> bcnt == LIM);
  assert_cmd_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ctrl_wr && (reg_wdata == 32'd1 || reg_wdata == 32'd2)) |=> !ready);
  assert_clear_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ctrl_wr && reg_wdata == 32'd0) |=> (ready && !fail));
  assert_bad_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ctrl_wr && reg_wdata > 32'd2) |=> (ready && fail));
  assert_fail_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> ready);
  assert_busy_wr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && reg_wr && reg_addr == 2'd1 && bcnt < LIM - 1'b1) |=> $stable(val_lo));
  assert_sec_bcd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec[3:0] <= 4'd9) && (sec <= 8'h59));
endmodule

bind rtc_cmd_front rtc_cmd_front_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ready(ready), .fail(fail), .val_lo(val_lo),
  .sec(cur_sec)
);

// File: tb/sim_rtc_cmd_front.sv
module sim_rtc_cmd_front;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int nvec = 0;
  int nbad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rtc_cmd_front #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {expect_fail, high, low}
  localparam logic [64:0] VECS [9] = '{
    {1'b0, 32'h00453014, 32'h03251123},  // valid
    {1'b1, 32'h00453014, 32'h01011323},  // month 13
    {1'b1, 32'h005A0000, 32'h00010100},  // second nibble A
    {1'b1, 32'h00000024, 32'h00010100},  // hour 24
    {1'b1, 32'h00000000, 32'h07010100},  // weekday 7
    {1'b1, 32'h00000000, 32'h00000100},  // day 00
    {1'b0, 32'h00595923, 32'h06311299},  // largest values
    {1'b1, 32'h00000000, 32'h000101A0},  // year nibble A
    {1'b1, 32'h00000000, 32'h00010000}   // month 00
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_ready();
    logic [31:0] c;
    rd(2'd0, c);
    while (!c[15]) begin
      @(negedge clk);
      rd(2'd0, c);
    end
  endtask

  task automatic set_time(input logic [31:0] lo, input logic [31:0] hi);
    wait_ready();
    wr(2'd0, 32'd0);
    wr(2'd1, lo);
    wr(2'd2, hi);
    wr(2'd0, 32'd1);
    wait_ready();
  endtask

  task automatic get_time(output logic [31:0] lo, output logic [31:0] hi);
    wait_ready();
    wr(2'd0, 32'd2);
    wait_ready();
    rd(2'd1, lo);
    rd(2'd2, hi);
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic tick_case(input string req, input logic [31:0] lo0, input logic [31:0] hi0,
                           input int n, input logic [31:0] lo1, input logic [31:0] hi1);
    logic [31:0] l, h;
    set_time(lo0, hi0);
    pulse_ticks(n);
    get_time(l, h);
    check(req, l, lo1);
    check(req, h, hi1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog (all) actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] d, lo, hi, good_lo, good_hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: reset state and register map
    rd(2'd0, d); check("R1 ctrl after reset", d, 32'h0000_8000);
    rd(2'd1, d); check("R1 lo after reset", d, 32'h0);
    rd(2'd2, d); check("R1 hi after reset", d, 32'h0);
    rd(2'd3, d); check("R2 addr3 reads zero", d, 32'h0);
    get_time(lo, hi);
    check("R1 R7 reset date", lo, 32'h00010100);
    check("R1 R7 reset time", hi, 32'h00000000);
    good_lo = lo; good_hi = hi;

    // R5 / R6 / R7: table of set attempts, each followed by a readback
    for (int i = 0; i < 9; i++) begin
      set_time(VECS[i][31:0], VECS[i][63:32]);
      rd(2'd0, d);
      check(VECS[i][64] ? "R6 fail bit after bad set" : "R5 status after good set",
            d, VECS[i][64] ? 32'h0000_C000 : 32'h0000_8000);
      if (!VECS[i][64]) begin good_lo = VECS[i][31:0]; good_hi = VECS[i][63:32]; end
      get_time(lo, hi);
      check("R5 R6 R7 clock low after set", lo, good_lo);
      check("R5 R6 R7 clock high after set", hi, good_hi);
      rd(2'd0, d);
      check("R7 read clears fail", d, 32'h0000_8000);
    end

    // R4: busy window length
    wait_ready();
    wr(2'd0, 32'd2);
    rd(2'd0, d); check("R4 busy right after command", d, 32'h0);
    repeat (BUSY - 1) @(negedge clk);
    rd(2'd0, d); check("R4 still busy at last cycle", d, 32'h0);
    @(negedge clk);
    rd(2'd0, d); check("R4 ready after busy window", d, 32'h0000_8000);

    // R8 then R3: unknown command value, then clear
    wr(2'd0, 32'd5);
    rd(2'd0, d); check("R8 unknown command fails at once", d, 32'h0000_C000);
    wr(2'd0, 32'hFFFF_0001);
    rd(2'd0, d); check("R8 wide unknown command", d, 32'h0000_C000);
    wr(2'd0, 32'd0);
    rd(2'd0, d); check("R3 zero clears fail", d, 32'h0000_8000);

    // R9: writes during busy are dropped
    wait_ready();
    wr(2'd0, 32'd0);
    wr(2'd1, 32'h02150623);
    wr(2'd2, 32'h00201510);
    wr(2'd0, 32'd1);
    wr(2'd1, 32'h07991399);
    wr(2'd0, 32'd5);
    wait_ready();
    rd(2'd0, d); check("R9 command write during busy ignored", d, 32'h0000_8000);
    rd(2'd1, d); check("R9 value write during busy ignored", d, 32'h02150623);
    get_time(lo, hi);
    check("R9 set used pre-busy low", lo, 32'h02150623);
    check("R9 set used pre-busy high", hi, 32'h00201510);

    // R10 / R11: counter chain
    tick_case("R10 second and minute carry", 32'h01150623, 32'h00590810, 2,
              32'h01150623, 32'h00010910);
    tick_case("R11 non-leap February", 32'h06280223, 32'h00595923, 1,
              32'h00010323, 32'h00000000);
    tick_case("R11 leap February", 32'h03280224, 32'h00595923, 1,
              32'h04290224, 32'h00000000);
    tick_case("R11 thirty-day month", 32'h02300423, 32'h00595923, 1,
              32'h03010523, 32'h00000000);
    tick_case("R11 year 99 wraps", 32'h05311299, 32'h00595923, 1,
              32'h06010100, 32'h00000000);
    tick_case("R10 hour carry", 32'h04100823, 32'h00595909, 1,
              32'h04100823, 32'h00000010);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule